// File: doc/BRIEF.md
# Oversampled Serial Character Receiver

This block receives asynchronous serial characters. A sample tick, pulsed for one clock at sixteen times the baud rate, paces all of its timing. The serial line is passed through a two-flop synchronizer. The receiver then waits for a low level that lasts long enough to count as a start bit, and ignores shorter lows as noise. Once a start is accepted, the receiver samples each later bit once, at the centre of that bit. The count is taken from the tick on which the line was first seen low.

Each frame is a start bit, eight data bits sent least-significant bit first, an optional parity bit and one stop bit. A finished character is copied into a holding register and a ready flag is raised. A one-clock read strobe drops the ready flag. Three sticky flags record parity errors, framing errors and overruns. A reset command stops the receiver at once, discards any partial character, turns reception off and clears the three error flags. An enable command turns reception back on.

Top module: `uart_rx_os`

## Requirements
- R1: A start bit is accepted when the synchronized line is low on 8 consecutive sample ticks. The first of those ticks is the reference tick, tick 0.
- R2: A low that lasts 7 ticks or fewer, followed by a high, starts no character. The receiver keeps waiting and its outputs do not change.
- R3: Data bit k (k = 0..7, bit 0 first) is sampled only on tick 24 + 16·k after tick 0, so the line only has to hold its value around the centre of each bit.
- R4: par_mode selects the parity: 2'b01 even, 2'b10 odd, 2'b00 or 2'b11 none. In the even and odd modes the parity bit follows the data, and a mismatch sets par_err. par_err stays set.
- R5: A stop bit sampled low sets frm_err. The character is still stored and rx_ready is still raised.
- R6: When the stop bit has been sampled, rx_data takes the character and rx_ready is set.
- R7: A rd_strobe pulse with no character completing in the same cycle clears rx_ready on the next clock edge.
- R8: If a character completes while rx_ready is set and rd_strobe is low in that cycle, rx_data is overwritten and ovr_err is set. If rd_strobe is high in that cycle, ovr_err stays low and rx_ready stays set.
- R9: cmd_reset aborts any frame in progress and turns reception off. It also clears par_err, frm_err and ovr_err, and it leaves rx_data and rx_ready unchanged. cmd_enable turns reception back on, and cmd_reset wins when both are high. While reception is off, no character is received.
- R10: After rst_n, reception is off and rx_data, rx_ready and all error flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| samp_tick | input | 1 | One-clock pulse at 16x the baud rate |
| rxd_i | input | 1 | Asynchronous serial input; idles high |
| cmd_enable | input | 1 | Pulse: turn reception on |
| cmd_reset | input | 1 | Pulse: abort, turn reception off, clear error flags |
| par_mode | input | 2 | 01 even, 10 odd, 00/11 no parity |
| rd_strobe | input | 1 | Pulse: holding register read |
| rx_data | output | 8 | Holding register |
| rx_ready | output | 1 | Character waiting in holding register |
| par_err | output | 1 | Sticky parity error |
| frm_err | output | 1 | Sticky framing error |
| ovr_err | output | 1 | Sticky overrun |

## Verification
A character can complete in the same clock cycle that software reads the holding register. In that cycle the read's clear of the ready flag and the completion's set of it collide. The bench provokes this by placing a read strobe exactly one clock after the tick that samples the stop bit, with an unread character already waiting. It then requires the new character to be present, the ready flag to be set and the overrun flag to be clear. A second pass holds the strobe low in that cycle and expects the overrun flag to be set.

// File: rtl/uart_rx_pkg.sv
// Shared types for the oversampled serial receiver.
package uart_rx_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DATA = 2'd1,
        ST_PAR  = 2'd2,
        ST_STOP = 2'd3
    } rx_state_e;

    localparam logic [1:0] PM_EVEN = 2'b01;
    localparam logic [1:0] PM_ODD  = 2'b10;
endpackage

// File: rtl/uart_rx_sync.sv
// Multi-flop synchronizer for the asynchronous serial line.
// Assumes the line idles high, so every stage resets to 1.
module uart_rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] q;

    // Shift the raw line through the synchronizer stages.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '1;
                else        q <= din;
            end
        end else begin : g_many
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '1;
                else        q <= {q[STAGES-2:0], din};
            end
        end
    endgenerate

    assign dout = q[STAGES-1];
endmodule

// File: rtl/uart_rx_fsm.sv
// Start qualification and bit timing. A single tick counter runs from the
// first low tick. A start is accepted after QUAL low ticks, and each later bit
// is sampled when the counter reaches FIRST. The counter is then reloaded so
// that the next sample falls OSR ticks later.
// Assumes par_mode is stable while start qualification runs.
module uart_rx_fsm
    import uart_rx_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OSR    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rxd_s,
    input  logic              enable,
    input  logic              abort,
    input  logic [1:0]        par_mode,
    output logic              done,
    output logic [DATA_W-1:0] data,
    output logic              perr,
    output logic              ferr
);
    localparam int QUAL   = OSR / 2;
    localparam int FIRST  = OSR + OSR / 2;
    localparam int RELOAD = FIRST - OSR + 1;
    localparam int CNT_W  = $clog2(FIRST + 1);
    localparam int BIT_W  = (DATA_W > 1) ? $clog2(DATA_W) : 1;

    rx_state_e         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bitc;
    logic [DATA_W-1:0] shreg;
    logic              par_bit, par_en_q, par_odd_q;
    logic              run, qual_hit, samp;

    assign run      = enable && !abort;
    assign qual_hit = run && tick && (state == ST_IDLE) && !rxd_s
                      && (cnt == CNT_W'(QUAL - 1));
    assign samp     = run && tick && (state != ST_IDLE)
                      && (cnt == CNT_W'(FIRST));

    // Control: state, tick counter and data-bit counter.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            state <= ST_IDLE;
            cnt   <= '0;
            bitc  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (tick) begin
                if (state == ST_IDLE) begin
                    if (rxd_s) begin
                        cnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (cnt == CNT_W'(QUAL - 1)) begin
                            state <= ST_DATA;
                            bitc  <= '0;
                        end
                    end
                end else if (cnt == CNT_W'(FIRST)) begin
                    cnt <= CNT_W'(RELOAD);
                    case (state)
                        ST_DATA: begin
                            bitc <= bitc + 1'b1;
                            if (bitc == BIT_W'(DATA_W - 1))
                                state <= par_en_q ? ST_PAR : ST_STOP;
                        end
                        ST_PAR:  state <= ST_STOP;
                        default: begin
                            state <= ST_IDLE;
                            cnt   <= '0;
                            done  <= 1'b1;
                        end
                    endcase
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // Datapath: latch the parity mode at start, shift bits in, build the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg     <= '0;
            par_bit   <= 1'b0;
            par_en_q  <= 1'b0;
            par_odd_q <= 1'b0;
            data      <= '0;
            perr      <= 1'b0;
            ferr      <= 1'b0;
        end else if (qual_hit) begin
            par_en_q  <= (par_mode == PM_EVEN) || (par_mode == PM_ODD);
            par_odd_q <= (par_mode == PM_ODD);
        end else if (samp) begin
            case (state)
                ST_DATA: shreg   <= {rxd_s, shreg[DATA_W-1:1]};
                ST_PAR:  par_bit <= rxd_s;
                default: begin
                    data <= shreg;
                    perr <= par_en_q && (par_bit ^ (^shreg) ^ par_odd_q);
                    ferr <= !rxd_s;
                end
            endcase
        end
    end

    AST_CNT_BOUND:  assert property (@(posedge clk) disable iff (!rst_n)
                        cnt <= CNT_W'(FIRST));                                  // R3
    AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
                        abort |=> (state == ST_IDLE && cnt == '0 && !done));    // R9
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                        done |=> !done);                                        // R6
    AST_START_LOW:  assert property (@(posedge clk) disable iff (!rst_n)
                        (state == ST_IDLE && $past(state) == ST_IDLE && cnt != '0)
                        |-> !$past(rxd_s) || !$past(tick));                     // R1
endmodule

// File: rtl/uart_rx_hold.sv
// Holding register, ready handshake and sticky error flags.
// Assumes done is a one-cycle pulse with d_in, perr_in and ferr_in valid.
module uart_rx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              done,
    input  logic [DATA_W-1:0] d_in,
    input  logic              perr_in,
    input  logic              ferr_in,
    input  logic              rd,
    input  logic              clr_err,
    output logic [DATA_W-1:0] data,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              ovr
);
    // Capture characters, run the ready handshake and keep the error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data  <= '0;
            ready <= 1'b0;
            perr  <= 1'b0;
            ferr  <= 1'b0;
            ovr   <= 1'b0;
        end else begin
            if (done) begin
                data  <= d_in;
                ready <= 1'b1;
                if (ready && !rd) ovr <= 1'b1;
                if (perr_in)      perr <= 1'b1;
                if (ferr_in)      ferr <= 1'b1;
            end else if (rd) begin
                ready <= 1'b0;
            end
            if (clr_err) begin
                perr <= 1'b0;
                ferr <= 1'b0;
                ovr  <= 1'b0;
            end
        end
    end

    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
                         (rd && !done) |=> !ready);                      // R7
    AST_DONE_SETS:   assert property (@(posedge clk) disable iff (!rst_n)
                         done |=> (ready && data == $past(d_in)));        // R6
    AST_OVR_SET:     assert property (@(posedge clk) disable iff (!rst_n)
                         (done && ready && !rd && !clr_err) |=> ovr);    // R8
    AST_OVR_NONE:    assert property (@(posedge clk) disable iff (!rst_n)
                         (!ovr && !(done && ready && !rd)) |=> !ovr);    // R8
    AST_ERR_CLEAR:   assert property (@(posedge clk) disable iff (!rst_n)
                         clr_err |=> (!perr && !ferr && !ovr));          // R9
endmodule

// File: rtl/uart_rx_os.sv
// Top of the oversampled serial receiver: synchronizer, timing FSM,
// holding register, and the enable state set and cleared by commands.
// Assumes samp_tick is a one-clock pulse and rxd_i is asynchronous.
module uart_rx_os #(
    parameter int DATA_W      = 8,
    parameter int OSR         = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              samp_tick,
    input  logic              rxd_i,
    input  logic              cmd_enable,
    input  logic              cmd_reset,
    input  logic [1:0]        par_mode,
    input  logic              rd_strobe,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);
    logic              rxd_s, rx_on, done, perr_c, ferr_c;
    logic [DATA_W-1:0] char_c;

    // Reception on/off state: the reset command wins over enable.
    always_ff @(posedge clk) begin
        if (!rst_n)          rx_on <= 1'b0;
        else if (cmd_reset)  rx_on <= 1'b0;
        else if (cmd_enable) rx_on <= 1'b1;
    end

    uart_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(rxd_i), .dout(rxd_s)
    );

    uart_rx_fsm #(.DATA_W(DATA_W), .OSR(OSR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .tick(samp_tick), .rxd_s(rxd_s),
        .enable(rx_on), .abort(cmd_reset), .par_mode(par_mode),
        .done(done), .data(char_c), .perr(perr_c), .ferr(ferr_c)
    );

    uart_rx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk(clk), .rst_n(rst_n), .done(done), .d_in(char_c),
        .perr_in(perr_c), .ferr_in(ferr_c), .rd(rd_strobe), .clr_err(cmd_reset),
        .data(rx_data), .ready(rx_ready), .perr(par_err), .ferr(frm_err),
        .ovr(ovr_err)
    );

    AST_RST_DISABLES: assert property (@(posedge clk) disable iff (!rst_n)
                          cmd_reset |=> !rx_on);                          // R9
    AST_OFF_NO_DONE:  assert property (@(posedge clk) disable iff (!rst_n)
                          !rx_on |-> !done);                              // R9
endmodule

// File: tb/uart_rx_os_tb_top.sv
`timescale 1ns/1ps
module uart_rx_os_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       samp_tick = 1'b0;
    logic       rxd_i = 1'b1;
    logic       cmd_enable = 1'b0;
    logic       cmd_reset = 1'b0;
    logic [1:0] par_mode = 2'b00;
    logic       rd_strobe = 1'b0;
    logic [7:0] rx_data;
    logic       rx_ready, par_err, frm_err, ovr_err;
    int         n_tests = 0;
    int         n_fail  = 0;

    always #2 clk = ~clk;

    uart_rx_os dut_i (
        .clk(clk), .rst_n(rst_n), .samp_tick(samp_tick), .rxd_i(rxd_i),
        .cmd_enable(cmd_enable), .cmd_reset(cmd_reset), .par_mode(par_mode),
        .rd_strobe(rd_strobe), .rx_data(rx_data), .rx_ready(rx_ready),
        .par_err(par_err), .frm_err(frm_err), .ovr_err(ovr_err)
    );

    function automatic logic has_par(input logic [1:0] m);
        return (m == 2'b01) || (m == 2'b10);
    endfunction

    function automatic logic good_par(input logic [7:0] d, input logic [1:0] m);
        return (m == 2'b10) ? ~(^d) : (^d);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One sample tick; rd asserts the read strobe one clock after the tick.
    task automatic tick1(input logic rd);
        repeat (3) @(negedge clk);
        samp_tick = 1'b1;
        @(negedge clk);
        samp_tick = 1'b0;
        rd_strobe = rd;
        @(negedge clk);
        rd_strobe = 1'b0;
    endtask

    task automatic drive_bit(input logic v, input bit centered, input int rd_idx);
        for (int i = 0; i < 16; i++) begin
            rxd_i = (centered && (i < 5 || i > 11)) ? ~v : v;
            tick1(i == rd_idx);
        end
    endtask

    task automatic idle(input int n);
        rxd_i = 1'b1;
        repeat (n) tick1(1'b0);
    endtask

    task automatic send(input logic [7:0] d, input logic [1:0] m, input bit bad_par,
                        input bit bad_stop, input bit centered, input bit rd_at_stop);
        par_mode = m;
        drive_bit(1'b0, 1'b0, -1);
        for (int b = 0; b < 8; b++) drive_bit(d[b], centered, -1);
        if (has_par(m)) drive_bit(good_par(d, m) ^ bad_par, centered, -1);
        drive_bit(!bad_stop, 1'b0, rd_at_stop ? 8 : -1);
        idle(3);
    endtask

    task automatic pulse_rd();
        @(negedge clk); rd_strobe = 1'b1;
        @(negedge clk); rd_strobe = 1'b0;
    endtask

    task automatic restart();
        @(negedge clk); cmd_reset = 1'b1;
        @(negedge clk); cmd_reset = 1'b0; cmd_enable = 1'b1;
        @(negedge clk); cmd_enable = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all R) actual=running expected=finished");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 ready", {31'd0, rx_ready}, 0);
        chk("R10 data", {24'd0, rx_data}, 0);
        chk("R10 flags", {29'd0, par_err, frm_err, ovr_err}, 0);
        // R9/R10: reception is off after reset, so a frame is ignored
        send(8'h3C, 2'b00, 0, 0, 0, 0);
        chk("R10 off after reset", {31'd0, rx_ready}, 0);
        // R9: enable and reset in the same cycle, reset wins
        @(negedge clk); cmd_enable = 1'b1; cmd_reset = 1'b1;
        @(negedge clk); cmd_enable = 1'b0; cmd_reset = 1'b0;
        send(8'h3C, 2'b00, 0, 0, 0, 0);
        chk("R9 reset wins", {31'd0, rx_ready}, 0);

        restart();
        // R3/R6: centred-window frame, LSB first
        send(8'hA5, 2'b00, 0, 0, 1, 0);
        chk("R6 ready", {31'd0, rx_ready}, 1);
        chk("R3 data", {24'd0, rx_data}, 32'hA5);
        pulse_rd();
        chk("R7 read clears", {31'd0, rx_ready}, 0);

        // R2: 7-tick low is ignored
        rxd_i = 1'b0; repeat (7) tick1(1'b0);
        idle(200);
        chk("R2 short low", {31'd0, rx_ready}, 0);
        chk("R2 data kept", {24'd0, rx_data}, 32'hA5);
        // R1: 8-tick low is a start; all later samples high -> 0xFF
        par_mode = 2'b00;
        rxd_i = 1'b0; repeat (8) tick1(1'b0);
        idle(200);
        chk("R1 start accepted", {31'd0, rx_ready}, 1);
        chk("R1 data", {24'd0, rx_data}, 32'hFF);
        chk("R1 no framing err", {31'd0, frm_err}, 0);
        pulse_rd();

        // R4: parity modes, good and bad
        send(8'h17, 2'b01, 0, 0, 0, 1);
        chk("R4 even good", {31'd0, par_err}, 0);
        send(8'h17, 2'b01, 1, 0, 0, 1);
        chk("R4 even bad", {31'd0, par_err}, 1);
        send(8'h00, 2'b00, 0, 0, 0, 1);
        chk("R4 sticky", {31'd0, par_err}, 1);
        restart();
        chk("R9 clears par", {31'd0, par_err}, 0);
        send(8'h17, 2'b10, 0, 0, 1, 1);
        chk("R4 odd good", {31'd0, par_err}, 0);
        send(8'hC3, 2'b10, 1, 0, 1, 1);
        chk("R4 odd bad", {31'd0, par_err}, 1);
        chk("R4 odd data", {24'd0, rx_data}, 32'hC3);
        pulse_rd();
        restart();

        // R5: stop low
        send(8'h5A, 2'b00, 0, 1, 0, 0);
        chk("R5 framing", {31'd0, frm_err}, 1);
        chk("R5 stored", {24'd0, rx_data}, 32'h5A);
        chk("R5 ready", {31'd0, rx_ready}, 1);
        pulse_rd();
        restart();
        chk("R9 clears frm", {31'd0, frm_err}, 0);

        // R8: overrun, then read colliding with completion
        send(8'h11, 2'b00, 0, 0, 0, 0);
        send(8'h22, 2'b00, 0, 0, 0, 0);
        chk("R8 overrun", {31'd0, ovr_err}, 1);
        chk("R8 overwritten", {24'd0, rx_data}, 32'h22);
        restart();
        chk("R9 clears ovr", {31'd0, ovr_err}, 0);
        chk("R9 ready kept", {31'd0, rx_ready}, 1);
        send(8'h33, 2'b00, 0, 0, 0, 1);
        chk("R8 collide ready", {31'd0, rx_ready}, 1);
        chk("R8 collide no ovr", {31'd0, ovr_err}, 0);
        chk("R8 collide data", {24'd0, rx_data}, 32'h33);
        pulse_rd();

        // R9: abort mid-frame, then receiver stays off
        par_mode = 2'b00;
        drive_bit(1'b0, 0, -1);
        for (int b = 0; b < 3; b++) drive_bit(1'b0, 0, -1);
        @(negedge clk); cmd_reset = 1'b1;
        @(negedge clk); cmd_reset = 1'b0;
        for (int b = 3; b < 8; b++) drive_bit(1'b0, 0, -1);
        drive_bit(1'b1, 0, -1);
        idle(20);
        chk("R9 abort", {31'd0, rx_ready}, 0);
        send(8'h44, 2'b00, 0, 0, 0, 0);
        chk("R9 disabled", {31'd0, rx_ready}, 0);
        restart();
        send(8'h44, 2'b00, 0, 0, 0, 0);
        chk("R9 re-enabled", {24'd0, rx_data}, 32'h44);
        pulse_rd();

        // Random frames: R3, R4, R5, R6, R7
        for (int k = 0; k < 24; k++) begin
            logic [7:0] d;
            logic [1:0] m;
            bit bp, bs, cen;
            d   = 8'($urandom);
            m   = 2'($urandom_range(0, 3));
            bp  = ($urandom_range(0, 7) == 0);
            bs  = ($urandom_range(0, 7) == 0);
            cen = ($urandom_range(0, 1) == 1);
            send(d, m, bp, bs, cen, 0);
            chk("R3 rand data", {24'd0, rx_data}, {24'd0, d});
            chk("R6 rand ready", {31'd0, rx_ready}, 1);
            chk("R4 rand par", {31'd0, par_err}, {31'd0, bp && has_par(m)});
            chk("R5 rand frm", {31'd0, frm_err}, {31'd0, bs});
            pulse_rd();
            chk("R7 rand read", {31'd0, rx_ready}, 0);
            restart();
        end

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule